// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the ordered list of column addresses for one read or write burst on a synchronous DRAM. A caller pulses a start strobe together with the first column and the current mode-register word. From the next clock on, the block presents one column address per cycle with a valid flag, and it raises a last flag on the final beat of a fixed-length burst. The burst length and the wrap order (linear or bit-flipping) are taken from the mode word when the burst starts. A full-page setting runs through the whole row and past its end until the caller ends it.

A terminate input ends any burst early. A new start during a burst abandons the old burst and begins the new one at once. The block only orders columns. It drives no memory pins, moves no data and keeps no timing between banks.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the first cycle after a clock edge that sampled reset high, col_valid and col_last are 0.
- R2: A start sampled at a clock edge makes col_valid 1 and col_addr equal to the sampled start_col in the following cycle. Each later cycle of the same burst presents the next beat's address.
- R3: Burst length comes from mode_word[2:0]: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 selects full page. The codes 100, 101 and 110 behave as a 1-beat burst.
- R4: When mode_word[3] is 0 (linear order) and the length is fixed at BL, beat k has the low log2(BL) address bits equal to (start low bits + k) mod BL. The upper bits stay equal to those of start_col.
- R5: When mode_word[3] is 1 (flip order) and the length is fixed at BL, beat k has the low log2(BL) bits equal to the start low bits XOR k. The upper bits stay unchanged.
- R6: In full-page mode, beat k is (start_col + k) mod 512 whatever mode_word[3] holds. The burst keeps going with col_last at 0 until it is terminated.
- R7: col_last is 1 exactly on the final beat of a fixed-length burst. col_valid is 0 in the cycle after it unless a new start was sampled.
- R8: A terminate sampled at an edge without a start makes col_valid 0 in the next cycle. A terminate while idle has no effect.
- R9: A start sampled during an active burst restarts from the new start_col. A start sampled together with terminate takes priority and begins a burst.
- R10: The mode word is captured only at the start edge. Changing it during a burst does not alter that burst's addresses, length or last flag, and bits above bit 3 never affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | MODE_W (12) | Mode-register word: [2:0] length code, [3] order select, higher bits unused here |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 9 | First column of the burst |
| terminate | input | 1 | End the current burst early |
| col_addr | output | 9 | Column address for this beat |
| col_valid | output | 1 | col_addr carries a beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
Linear bursts of every fixed length are started from both aligned and misaligned columns, so a wrap that leaks a carry into the upper bits is caught. Flip-order bursts use the same misaligned starts, because only a misaligned start makes XOR and addition give different sequences. A full-page run of more than 512 beats shows the wrap at column 511 and the missing last flag. Terminates in the middle of a burst, while idle and together with a start, a restart in the middle of a burst, reserved length codes and a mode word that changes during a burst each test one control rule. The bench compares all of these against a model built on integer arithmetic.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W = 9;
    localparam int LEN_W = 3;

    typedef enum logic [LEN_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef struct packed {
        logic             full;
        logic             flip;
        logic [COL_W-1:0] mask;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_cfg(input logic [LEN_W-1:0] code, input logic order_bit);
        burst_cfg_t c;
        c.full = 1'b0;
        c.flip = order_bit;
        case (code)
            LEN_TWO:   c.mask = COL_W'(1);
            LEN_FOUR:  c.mask = COL_W'(3);
            LEN_EIGHT: c.mask = COL_W'(7);
            LEN_PAGE: begin
                c.mask = '1;
                c.full = 1'b1;
                c.flip = 1'b0;
            end
            default:   c.mask = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg
);
    localparam int ORDER_BIT = LEN_W;

    always_comb begin
        cfg = decode_cfg(mode_word[LEN_W-1:0], mode_word[ORDER_BIT]);
    end
endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             terminate,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] base,
    output burst_cfg_t       cfg_q,
    output logic             final_beat
);
    assign final_beat = active && !cfg_q.full && (beat == cfg_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
            base   <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= start_col;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (terminate || final_beat) begin
                active <= 1'b0;
            end else begin
                beat <= beat + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/burst_addr_order.sv
module burst_addr_order
    import burst_pkg::*;
(
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] linear_sum;
    assign linear_sum = base + beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!cfg.mask[i]) begin
                addr[i] = base[i];
            end else if (cfg.flip) begin
                addr[i] = base[i] ^ beat[i];
            end else begin
                addr[i] = linear_sum[i];
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              terminate,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last
);
    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_run;
    logic             run;
    logic             at_end;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] base_col;

    burst_cfg_decode #(.MODE_W(MODE_W)) u_dec (
        .mode_word (mode_word),
        .cfg       (cfg_new)
    );

    burst_beat_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .terminate  (terminate),
        .start_col  (start_col),
        .cfg_in     (cfg_new),
        .active     (run),
        .beat       (beat_idx),
        .base       (base_col),
        .cfg_q      (cfg_run),
        .final_beat (at_end)
    );

    burst_addr_order u_ord (
        .base (base_col),
        .beat (beat_idx),
        .cfg  (cfg_run),
        .addr (col_addr)
    );

    assign col_valid = run;
    assign col_last  = at_end;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       terminate,
    input logic [8:0] start_col,
    input logic [8:0] col_addr,
    input logic       col_valid,
    input logic       col_last
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!col_valid && !col_last));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !rst) |=> (col_valid && col_addr == $past(start_col)));

    assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid);

    assert_term_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (terminate && !start) |=> !col_valid);

    assert_burst_continues_R6: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !terminate) |=> col_valid);
endmodule

bind burst_col_gen burst_col_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .terminate (terminate),
    .start_col (start_col),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_word = '0;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        terminate = 1'b0;
    logic [8:0]  col_addr;
    logic        col_valid;
    logic        col_last;

    int vectors = 0;
    int miscompares = 0;
    string req = "R1";
    bit finished = 0;

    // reference model state
    bit m_active = 0;
    int m_beat = 0;
    int m_base = 0;
    int m_len = 1;
    bit m_full = 0;
    bit m_flip = 0;

    burst_col_gen uut (
        .clk(clk), .rst(rst), .mode_word(mode_word), .start(start),
        .start_col(start_col), .terminate(terminate),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0;
        end else if (start) begin
            m_active = 1;
            m_beat = 0;
            m_base = start_col;
            m_full = (mode_word[2:0] == 3'd7);
            m_flip = mode_word[3];
            case (mode_word[2:0])
                3'd1: m_len = 2;
                3'd2: m_len = 4;
                3'd3: m_len = 8;
                3'd7: m_len = 512;
                default: m_len = 1;
            endcase
        end else if (m_active) begin
            if (terminate || (!m_full && m_beat == m_len - 1)) m_active = 0;
            else m_beat = m_beat + 1;
        end
    end

    always @(negedge clk) begin
        int lo, hi, exp_addr;
        bit exp_last;
        lo = m_base % m_len;
        hi = m_base - lo;
        if (m_flip && !m_full) exp_addr = hi + (lo ^ m_beat);
        else exp_addr = hi + ((lo + m_beat) % m_len);
        exp_last = m_active && !m_full && (m_beat == m_len - 1);
        vectors++;
        if (col_valid !== m_active) begin
            miscompares++;
            $display("FAIL %s: col_valid actual %0b expected %0b at %0t", req, col_valid, m_active, $time);
        end else if (col_last !== exp_last) begin
            miscompares++;
            $display("FAIL %s: col_last actual %0b expected %0b at %0t", req, col_last, exp_last, $time);
        end else if (m_active && col_addr !== 9'(exp_addr)) begin
            miscompares++;
            $display("FAIL %s: col_addr actual %0d expected %0d at %0t", req, col_addr, exp_addr, $time);
        end
    end

    task automatic step(input bit s, input int col, input int mode, input bit t);
        start = s;
        start_col = 9'(col);
        mode_word = 12'(mode);
        terminate = t;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic burst(input int col, input int mode, input int wait_cycles);
        step(1, col, mode, 0);
        idle(wait_cycles);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        idle(2);

        // R2 R3 R4: linear bursts of every length, aligned and misaligned
        req = "R4";
        burst(9'h040, 12'h000, 3);
        burst(9'h041, 12'h001, 4);
        burst(9'h0A2, 12'h002, 6);
        burst(9'h1FD, 12'h003, 10);
        burst(9'h008, 12'h003, 10);

        // R5: flip order
        req = "R5";
        burst(9'h013, 12'h00A, 6);
        burst(9'h0F5, 12'h00B, 10);
        burst(9'h101, 12'h009, 4);

        // R3: reserved length codes act as one beat
        req = "R3";
        burst(9'h033, 12'h004, 2);
        burst(9'h034, 12'h005, 2);
        burst(9'h035, 12'h00E, 2);

        // R6: full page across the 511 wrap, order bit set, then terminate
        req = "R6";
        step(1, 9'h1F0, 12'h00F, 0);
        idle(530);
        req = "R8";
        step(0, 0, 0, 1);
        idle(3);

        // R8: terminate in the middle of a fixed burst, and while idle
        burst(9'h020, 12'h003, 2);
        step(0, 0, 0, 1);
        idle(3);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        idle(2);

        // R9: restart in mid burst; start beats terminate
        req = "R9";
        burst(9'h050, 12'h003, 2);
        burst(9'h066, 12'h00A, 6);
        step(1, 9'h077, 12'h002, 1);
        idle(6);

        // R10: mode word changes during the burst, high bits ignored
        req = "R10";
        step(1, 9'h0C5, 12'hFF2, 0);
        step(0, 0, 12'h00F, 0);
        step(0, 0, 12'h00B, 0);
        idle(6);

        // R7: single-beat and back-to-back bursts check last flag timing
        req = "R7";
        burst(9'h111, 12'h000, 0);
        burst(9'h112, 12'h001, 0);
        burst(9'h113, 12'h001, 3);

        // R1: reset in the middle of a burst
        req = "R1";
        step(1, 9'h010, 12'h003, 0);
        idle(2);
        rst = 1;
        idle(2);
        rst = 0;
        idle(3);

        finish_run();
    end
endmodule